// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Sequencer

This block decides when the transmit side of an Ethernet MAC may place the link in low-power idle (LPI) and when it may start sending again. Software provides a link-status bit, an LPI enable bit and an automate bit, and the transmit path raises a pending request whenever it has a frame to send. The block asserts an LPI request toward the PHY interface only after the link has been reported good for a programmed number of milliseconds and no frame is waiting. It drops that request as soon as a frame arrives or software withdraws permission. It then holds transmission off for a programmed number of microseconds so the far end has time to wake.

Both timers come from one 27-bit timer control word. Microsecond and millisecond ticks are derived internally from a clock-frequency parameter. Four sticky event flags record transmit and receive entry into and exit from LPI. The receive events come from a single pin driven by the PHY side. The flags clear on a read strobe, and a summary interrupt stays high while any flag is pending.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, lpiAssert is 0, txAllowed is 1, statusFlags is 0 and lpiIrq is 0.
- R2: timerCtrl[15:0] is the wake time in microseconds and timerCtrl[26:16] is the link-stable time in milliseconds.
- R3: lpiAssert rises only after linkUp has been continuously 1 for at least the link-stable time, and no later than one further millisecond plus two clock cycles.
- R4: LPI is entered only while lpiEnable and txAutomate are both 1 and txPending is 0; with only one of the two bits set the block stays out of LPI.
- R5: While lpiAssert is 1, txAllowed is 0; the two outputs are never 1 together.
- R6: In LPI, txPending at 1, or either lpiEnable or txAutomate at 0, drops lpiAssert at the next clock edge. txAllowed then stays 0 for at least the wake time and returns to 1 within the wake time plus one microsecond plus two cycles.
- R7: linkUp at 0 in LPI drops lpiAssert and raises txAllowed at the next edge without a wake wait, and restarts the link-stable count.
- R8: statusFlags bit 0 sets when lpiAssert rises and bit 1 sets when lpiAssert falls.
- R9: rxLpiIn is sampled each cycle. A rising edge sets statusFlags bit 2 and a falling edge sets bit 3.
- R10: A statusRead strobe clears all four flags at the next edge; an event in the same cycle as the strobe still leaves its flag set.
- R11: lpiIrq is 1 exactly while any statusFlags bit is 1.
- R12: One microsecond is CLK_FREQ_HZ/1,000,000 cycles, and one millisecond is US_PER_MS microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lpiEnable | input | 1 | Software permission for LPI |
| txAutomate | input | 1 | Automatic transmit LPI entry and exit |
| linkUp | input | 1 | Software-reported link status |
| txPending | input | 1 | Transmit path has a frame waiting |
| rxLpiIn | input | 1 | Receive-side LPI indication |
| timerCtrl | input | 27 | [26:16] link-stable ms, [15:0] wake us |
| statusRead | input | 1 | Read strobe that clears the flags |
| lpiAssert | output | 1 | LPI request toward the PHY interface |
| txAllowed | output | 1 | Transmission may proceed |
| statusFlags | output | 4 | {rxExit, rxEnter, txExit, txEnter} |
| lpiIrq | output | 1 | Summary interrupt |

## Verification
The sequencer is driven through four patterns. A fresh link-up with the request already set shows whether the link-stable gate counts whole milliseconds. A frame arriving during LPI shows whether the wake wait is honoured and whether a still-pending frame blocks re-entry. Withdrawing software permission, alone and with one bit left set, separates the AND of the two enables from an OR. Dropping the link in LPI and raising it again shows that the stable count restarts, not resumes. The flag readouts, including a receive edge that lands in the same cycle as a read, separate clear-on-read priority from a plain clear.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  localparam int WAKE_W = 16;
  localparam int LINK_W = 11;
  localparam int CTRL_W = 27;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LINK = 2'd1,
    ST_LPI       = 2'd2,
    ST_WAKE      = 2'd3
  } lpiState_e;

  typedef struct packed {
    logic enterLpi;
    logic exitLpi;
    logic startWake;
  } lpiStrobe_t;
endpackage

// File: rtl/eee_lpi_tick.sv
module eee_lpi_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic inTick,
  output logic outTick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : gPass
      assign outTick = inTick;
    end else begin : gDivide
      logic [CNT_W-1:0] divCnt;
      logic atEnd;
      assign atEnd = (divCnt == CNT_W'(DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          divCnt <= '0;
        else if (inTick)    divCnt <= atEnd ? '0 : divCnt + 1'b1;
      end
      assign outTick = inTick && atEnd;
    end
  endgenerate
endmodule

// File: rtl/eee_lpi_datapath.sv
module eee_lpi_datapath
  import eee_lpi_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int US_PER_MS   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              rxLpiIn,
  input  logic              statusRead,
  input  logic [CTRL_W-1:0] timerCtrl,
  input  lpiStrobe_t        strobe,
  output logic              linkGood,
  output logic              wakeDone,
  output logic [3:0]        statusFlags
);
  localparam int CYC_PER_US = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;

  logic usTick, msTick;
  logic [WAKE_W-1:0] wakeUs;
  logic [LINK_W-1:0] linkMs;
  logic [LINK_W:0]   linkCnt;
  logic [WAKE_W:0]   wakeCnt;
  logic rxQ, rxRise, rxFall;
  logic [3:0] setVec;

  assign wakeUs = timerCtrl[WAKE_W-1:0];
  assign linkMs = timerCtrl[WAKE_W+LINK_W-1:WAKE_W];

  eee_lpi_tick #(.DIV(CYC_PER_US)) usGen (.clk(clk), .rstN(rstN), .inTick(1'b1),   .outTick(usTick));
  eee_lpi_tick #(.DIV(US_PER_MS))  msGen (.clk(clk), .rstN(rstN), .inTick(usTick), .outTick(msTick));

  // link-stable count: whole ms ticks seen while the link stays up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        linkCnt <= '0;
    else if (!linkUp)                 linkCnt <= '0;
    else if (msTick && !(&linkCnt))   linkCnt <= linkCnt + 1'b1;
  end
  assign linkGood = linkUp && (linkCnt > {1'b0, linkMs});

  // wake count: microsecond ticks since LPI signalling stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        wakeCnt <= '0;
    else if (strobe.startWake)        wakeCnt <= '0;
    else if (usTick && !wakeDone)     wakeCnt <= wakeCnt + 1'b1;
  end
  assign wakeDone = wakeCnt > {1'b0, wakeUs};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxQ <= 1'b0;
    else       rxQ <= rxLpiIn;
  end
  assign rxRise = rxLpiIn && !rxQ;
  assign rxFall = !rxLpiIn && rxQ;

  assign setVec = {rxFall, rxRise, strobe.exitLpi, strobe.enterLpi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusFlags <= '0;
    else       statusFlags <= (statusRead ? 4'b0000 : statusFlags) | setVec;
  end
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_lpi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpiEnable,
  input  logic       txAutomate,
  input  logic       linkUp,
  input  logic       txPending,
  input  logic       linkGood,
  input  logic       wakeDone,
  output lpiStrobe_t strobe,
  output logic       lpiAssert,
  output logic       txAllowed
);
  lpiState_e state, nextState;
  logic lpiReq;

  assign lpiReq = lpiEnable && txAutomate;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:      if (linkUp && lpiReq) nextState = ST_WAIT_LINK;
      ST_WAIT_LINK: if (!linkUp || !lpiReq) nextState = ST_IDLE;
                    else if (linkGood && !txPending) nextState = ST_LPI;
      ST_LPI:       if (!linkUp) nextState = ST_IDLE;
                    else if (txPending || !lpiReq) nextState = ST_WAKE;
      ST_WAKE:      if (!linkUp || wakeDone) nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobe.enterLpi  = (state != ST_LPI)  && (nextState == ST_LPI);
  assign strobe.exitLpi   = (state == ST_LPI)  && (nextState != ST_LPI);
  assign strobe.startWake = (state != ST_WAKE) && (nextState == ST_WAKE);

  assign lpiAssert = (state == ST_LPI);
  assign txAllowed = (state == ST_IDLE) || (state == ST_WAIT_LINK);
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int US_PER_MS   = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lpiEnable,
  input  logic        txAutomate,
  input  logic        linkUp,
  input  logic        txPending,
  input  logic        rxLpiIn,
  input  logic [26:0] timerCtrl,
  input  logic        statusRead,
  output logic        lpiAssert,
  output logic        txAllowed,
  output logic [3:0]  statusFlags,
  output logic        lpiIrq
);
  lpiStrobe_t strobe;
  logic linkGood, wakeDone;

  eee_lpi_fsm ctrl (
    .clk(clk), .rstN(rstN), .lpiEnable(lpiEnable), .txAutomate(txAutomate),
    .linkUp(linkUp), .txPending(txPending), .linkGood(linkGood),
    .wakeDone(wakeDone), .strobe(strobe), .lpiAssert(lpiAssert), .txAllowed(txAllowed)
  );

  eee_lpi_datapath #(.CLK_FREQ_HZ(CLK_FREQ_HZ), .US_PER_MS(US_PER_MS)) dp (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .rxLpiIn(rxLpiIn),
    .statusRead(statusRead), .timerCtrl(timerCtrl), .strobe(strobe),
    .linkGood(linkGood), .wakeDone(wakeDone), .statusFlags(statusFlags)
  );

  assign lpiIrq = |statusFlags;
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int US_PER_MS   = 1000
) (
  input logic        clk,
  input logic        rstN,
  input logic        lpiEnable,
  input logic        txAutomate,
  input logic        linkUp,
  input logic        txPending,
  input logic [26:0] timerCtrl,
  input logic        lpiAssert,
  input logic        txAllowed,
  input logic        txEnterFlag,
  input logic        txExitFlag
);
  localparam int CYC_PER_US = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
  localparam int CYC_PER_MS = CYC_PER_US * US_PER_MS;

  logic [31:0] linkHighCyc, sinceLpiCyc, linkNeed, wakeNeed;

  assign linkNeed = 32'(timerCtrl[26:16]) * 32'(CYC_PER_MS);
  assign wakeNeed = 32'(timerCtrl[15:0]) * 32'(CYC_PER_US);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 linkHighCyc <= '0;
    else if (!linkUp)          linkHighCyc <= '0;
    else if (!(&linkHighCyc))  linkHighCyc <= linkHighCyc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceLpiCyc <= '1;
    else if (lpiAssert)        sinceLpiCyc <= '0;
    else if (!(&sinceLpiCyc))  sinceLpiCyc <= sinceLpiCyc + 1'b1;
  end

  // R5
  lpi_tx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lpiAssert && txAllowed));

  // R3
  link_stable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpiAssert) |-> (linkHighCyc >= linkNeed));

  // R4
  entry_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpiAssert) |-> $past(lpiEnable && txAutomate && !txPending));

  // R6
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txAllowed) && linkUp) |-> (sinceLpiCyc >= wakeNeed));

  // R8
  tx_enter_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpiAssert) |-> txEnterFlag);

  // R8
  tx_exit_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lpiAssert) |-> txExitFlag);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk #(.CLK_FREQ_HZ(CLK_FREQ_HZ), .US_PER_MS(US_PER_MS)) chk (
  .clk(clk), .rstN(rstN), .lpiEnable(lpiEnable), .txAutomate(txAutomate),
  .linkUp(linkUp), .txPending(txPending), .timerCtrl(timerCtrl),
  .lpiAssert(lpiAssert), .txAllowed(txAllowed),
  .txEnterFlag(statusFlags[0]), .txExitFlag(statusFlags[1])
);

// File: tb/eee_lpi_ctrl_test.sv
module eee_lpi_ctrl_test;
  localparam int CLK_HZ   = 4_000_000;   // 4 cycles per us
  localparam int US_MS    = 5;           // 20 cycles per ms
  localparam int CYC_MS   = 20;
  localparam int LINK_MS  = 3;
  localparam int WAKE_US  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lpiEnable = 0, txAutomate = 0, linkUp = 0, txPending = 0, rxLpiIn = 0, statusRead = 0;
  logic [26:0] timerCtrl = '0;
  logic lpiAssert, txAllowed, lpiIrq;
  logic [3:0] statusFlags;

  int checks = 0;
  int fails = 0;
  logic [3:0] expQ[$];
  string      reqQ[$];

  always #10 clk = ~clk;

  eee_lpi_ctrl #(.CLK_FREQ_HZ(CLK_HZ), .US_PER_MS(US_MS)) uut (
    .clk(clk), .rstN(rstN), .lpiEnable(lpiEnable), .txAutomate(txAutomate),
    .linkUp(linkUp), .txPending(txPending), .rxLpiIn(rxLpiIn), .timerCtrl(timerCtrl),
    .statusRead(statusRead), .lpiAssert(lpiAssert), .txAllowed(txAllowed),
    .statusFlags(statusFlags), .lpiIrq(lpiIrq)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares flags seen on each read strobe
  always begin
    @(negedge clk);
    #1;
    if (statusRead && expQ.size() > 0) begin
      logic [3:0] e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      checks++;
      if (statusFlags !== e) begin
        fails++;
        $display("FAIL %s status read: actual %b expected %b", r, statusFlags, e);
      end
    end
  end

  task automatic readStatus(input logic [3:0] exp, input string req);
    expQ.push_back(exp);
    reqQ.push_back(req);
    @(negedge clk) statusRead = 1;
    @(negedge clk) statusRead = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitLpi(output int n, input int limit);
    n = 0;
    while (!lpiAssert && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic waitTx(output int n, input int limit);
    n = 0;
    while (!txAllowed && n < limit) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    idle(2);
    // R1 reset state
    check(lpiAssert == 0 && txAllowed == 1, "R1", "outputs in reset", {lpiAssert, txAllowed}, 1);
    rstN = 1;
    idle(2);
    check(statusFlags == 0 && lpiIrq == 0, "R1", "flags after reset", {lpiIrq, statusFlags}, 0);

    // R2 R3 R12 link-stable gate: 3 ms link, 2 us wake, junk-free fields
    timerCtrl = {11'(LINK_MS), 16'(WAKE_US)};
    lpiEnable = 1; txAutomate = 1;
    linkUp = 1;
    waitLpi(n, 200);
    check(n >= LINK_MS * CYC_MS - 2, "R3", "entry not before link-stable time", n, LINK_MS * CYC_MS);
    check(n <= (LINK_MS + 1) * CYC_MS + 4, "R12", "entry within one further ms", n, (LINK_MS + 1) * CYC_MS);
    check(txAllowed == 0, "R5", "txAllowed low in LPI", txAllowed, 0);
    check(lpiIrq == 1, "R11", "irq with pending flag", lpiIrq, 1);
    readStatus(4'b0001, "R8");
    readStatus(4'b0000, "R10");
    check(lpiIrq == 0, "R11", "irq after clear", lpiIrq, 0);

    // R6 frame arrives in LPI
    txPending = 1;
    @(negedge clk);
    check(lpiAssert == 0, "R6", "LPI drops next edge on pending tx", lpiAssert, 0);
    waitTx(n, 100);
    n = n + 1;
    check(n >= WAKE_US * 4, "R6", "wake hold lower bound", n, WAKE_US * 4);
    check(n <= (WAKE_US + 1) * 4 + 3, "R6", "wake hold upper bound", n, (WAKE_US + 1) * 4);
    idle(30);
    check(lpiAssert == 0, "R4", "no re-entry with pending tx", lpiAssert, 0);
    readStatus(4'b0010, "R8");

    txPending = 0;
    idle(3);
    check(lpiAssert == 1, "R4", "re-entry once tx idle", lpiAssert, 1);

    // R6 software withdraws both bits
    lpiEnable = 0; txAutomate = 0;
    @(negedge clk);
    check(lpiAssert == 0, "R6", "LPI drops on cleared request", lpiAssert, 0);
    waitTx(n, 100);
    n = n + 1;
    check(n >= WAKE_US * 4 && n <= (WAKE_US + 1) * 4 + 3, "R6", "wake after withdraw", n, WAKE_US * 4);
    readStatus(4'b0011, "R8");

    // R4 only one permission bit
    lpiEnable = 1;
    idle(100);
    check(lpiAssert == 0, "R4", "enable without automate", lpiAssert, 0);
    lpiEnable = 0; txAutomate = 1;
    idle(100);
    check(lpiAssert == 0, "R4", "automate without enable", lpiAssert, 0);
    readStatus(4'b0000, "R4");

    // R7 link loss in LPI, then count restarts
    lpiEnable = 1;
    waitLpi(n, 10);
    check(lpiAssert == 1, "R4", "entry with both bits", lpiAssert, 1);
    linkUp = 0;
    @(negedge clk);
    check(lpiAssert == 0 && txAllowed == 1, "R7", "link loss exit", {lpiAssert, txAllowed}, 1);
    idle(5);
    linkUp = 1;
    waitLpi(n, 200);
    check(n >= LINK_MS * CYC_MS - 2 && n <= (LINK_MS + 1) * CYC_MS + 4, "R7", "link-stable restart", n, LINK_MS * CYC_MS);
    readStatus(4'b0011, "R8");
    lpiEnable = 0; txAutomate = 0;
    waitTx(n, 100);
    readStatus(4'b0010, "R8");

    // R9 receive pin edges
    rxLpiIn = 1;
    idle(3);
    readStatus(4'b0100, "R9");
    rxLpiIn = 0;
    idle(3);
    readStatus(4'b1000, "R9");

    // R10 event in the same cycle as the read survives
    expQ.push_back(4'b0000);
    reqQ.push_back("R10");
    @(negedge clk) begin statusRead = 1; rxLpiIn = 1; end
    @(negedge clk) statusRead = 0;
    idle(2);
    readStatus(4'b0100, "R10");
    check(lpiIrq == 0, "R11", "irq after final clear", lpiIrq, 0);

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule